// File: doc/BRIEF.md
# Receive Character Buffer with Watermark and Ageing Timer

This block sits behind a serial receiver and holds incoming characters until the register read path takes them. Each stored word carries the received byte together with its error markers. The receiver pushes one character per strobe, and a break condition arrives as its own flagged push. A pop strobe removes the oldest word and presents it, with a character-ready marker, on a registered output.

The buffer raises a receive-ready flag once its fill reaches a programmable trigger level. It also keeps a data-ready flag and an empty flag, and two sticky error indicators: one for characters lost to a full buffer and one for detected breaks. The word written into the final free slot carries an overrun tag, so software can tell where the loss began. When a few characters sit below the trigger level for a long time, an ageing timer flags them so they are not stranded. The timer measures time in character periods, each built from a parameterised number of ticks. A free-space count for the upstream receiver drops to zero whenever reception is disabled.

Top module: `uart_rx_age_fifo`

## Requirements
- R1: After synchronous reset, empty_o is 1 and data_ready_o, rx_ready_o, overrun_err_o, break_det_o, age_flag_o and pop_word_o are all 0.
- R2: Words leave in the order they were pushed. A pop with at least one word stored sets pop_word_o on the next clock edge to the stored word with bit 12 (character ready) set. A push and a pop in the same cycle are both performed.
- R3: A push while DEPTH words are stored is dropped and does not change the contents. It sets overrun_err_o, which stays set until reset.
- R4: A push that lands while DEPTH-1 words are stored writes its word with bit 10 (overrun tag) and bit 11 (error) set.
- R5: After any push or valid pop, rx_ready_o equals (stored count >= trig_lvl_i).
- R6: After any push or valid pop, empty_o is 1 exactly when the count is zero, and data_ready_o is its inverse.
- R7: A pop while empty makes pop_word_o zero and leaves every flag unchanged.
- R8: A push with push_brk_i stores data 0 with bits 8 (break), 9 (framing) and 11 (error) set, and sets break_det_o until reset.
- R9: A push with push_frm_i stores the byte in bits 7:0 with bits 9 and 11 set.
- R10: age_flag_o sets on the clock edge that counts the AGE_CHARS*TICKS_PER_CHAR-th char_tick_i after the last push or pop. The timer runs only while the buffer is non-empty and rx_ready_o is 0, and it is stopped otherwise.
- R11: A valid pop clears age_flag_o.
- R12: free_cnt_o is DEPTH minus the stored count while rx_en_i is 1, and 0 while rx_en_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en_i | input | 1 | Receiver enabled |
| trig_lvl_i | input | TRIG_W | Receive-ready trigger level |
| char_tick_i | input | 1 | Prescaler tick; TICKS_PER_CHAR of them make one character time |
| push_i | input | 1 | Push one character |
| push_data_i | input | 8 | Received byte |
| push_brk_i | input | 1 | Push is a break event |
| push_frm_i | input | 1 | Character had a framing error |
| pop_i | input | 1 | Read strobe from the register path |
| pop_word_o | output | 13 | Last popped word: data[7:0], break[8], framing[9], overrun[10], error[11], char ready[12] |
| rx_ready_o | output | 1 | Fill at or above trigger level |
| data_ready_o | output | 1 | At least one word stored |
| empty_o | output | 1 | No word stored |
| overrun_err_o | output | 1 | Sticky: a character was dropped |
| break_det_o | output | 1 | Sticky: a break was received |
| age_flag_o | output | 1 | Characters aged below the trigger level |
| free_cnt_o | output | CNT_W | Free slots offered upstream |

## Verification
Every flag, the popped word and the ageing flag are registered, so they show the effect of a push or pop one clock edge after the edge that takes it. free_cnt_o follows rx_en_i within the same cycle. The bench drives inputs on the falling edge and compares all outputs on the next falling edge against its own model of the queue. The ageing check counts exactly AGE_CHARS*TICKS_PER_CHAR ticking edges after the last push: the flag must still be low one edge before that point and high on it.

// File: rtl/uart_rxaf_pkg.sv
package uart_rxaf_pkg;

  localparam int DATA_W  = 8;
  localparam int WORD_W  = 12;
  localparam int OUT_W   = WORD_W + 1;

  localparam int B_BRK   = 8;
  localparam int B_FRM   = 9;
  localparam int B_OVR   = 10;
  localparam int B_ERR   = 11;
  localparam int B_RDY   = 12;

  // Builds the stored word from a receive event.
  function automatic logic [WORD_W-1:0] make_word(
    input logic [DATA_W-1:0] data,
    input logic              brk,
    input logic              frm,
    input logic              last_slot
  );
    logic [WORD_W-1:0] w;
    w = '0;
    w[DATA_W-1:0] = brk ? '0 : data;
    if (brk) begin
      w[B_BRK] = 1'b1;
      w[B_FRM] = 1'b1;
      w[B_ERR] = 1'b1;
    end
    if (frm) begin
      w[B_FRM] = 1'b1;
      w[B_ERR] = 1'b1;
    end
    if (last_slot) begin
      w[B_OVR] = 1'b1;
      w[B_ERR] = 1'b1;
    end
    return w;
  endfunction

  // Watermark comparison used for the ready flag.
  function automatic logic level_met(input int unsigned fill, input int unsigned trig);
    return fill >= trig;
  endfunction

  // Circular pointer advance for any depth.
  function automatic int unsigned wrap_next(input int unsigned ptr, input int unsigned depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

endpackage

// File: rtl/rxaf_store.sv
module rxaf_store #(
  parameter int DEPTH  = 32,
  parameter int WORD_W = 12,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_word,
  output logic [CNT_W-1:0]  count_o
);
  import uart_rxaf_pkg::*;

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (wr_en) wr_ptr <= PTR_W'(wrap_next(int'(wr_ptr), DEPTH));
      if (rd_en) rd_ptr <= PTR_W'(wrap_next(int'(rd_ptr), DEPTH));
      case ({wr_en, rd_en})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign rd_word = mem[rd_ptr];
  assign count_o = count_q;

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
    count_q <= CNT_W'(DEPTH));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (count_q == CNT_W'(DEPTH)) |-> !wr_en);

  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
    (count_q == '0) |-> !rd_en);

endmodule

// File: rtl/rxaf_status.sv
module rxaf_status #(
  parameter int CNT_W  = 6,
  parameter int TRIG_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_seen,
  input  logic              push_dropped,
  input  logic              brk_seen,
  input  logic              pop_valid,
  input  logic [CNT_W-1:0]  cnt_next,
  input  logic [TRIG_W-1:0] trig,
  output logic              rx_ready,
  output logic              data_ready,
  output logic              empty,
  output logic              overrun_err,
  output logic              break_det
);
  import uart_rxaf_pkg::*;

  logic update_ev;
  assign update_ev = push_seen || pop_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_ready    <= 1'b0;
      data_ready  <= 1'b0;
      empty       <= 1'b1;
      overrun_err <= 1'b0;
      break_det   <= 1'b0;
    end else begin
      if (update_ev) begin
        rx_ready   <= level_met(int'(cnt_next), int'(trig));
        empty      <= (cnt_next == '0);
        data_ready <= (cnt_next != '0);
      end
      if (push_dropped) overrun_err <= 1'b1;
      if (brk_seen)     break_det   <= 1'b1;
    end
  end

  assert_empty_vs_ready_R6: assert property (@(posedge clk) disable iff (rst)
    empty != data_ready);

  assert_overrun_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    overrun_err |=> overrun_err);

  assert_break_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    break_det |=> break_det);

  assert_flags_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !update_ev |=> ($stable(rx_ready) && $stable(empty)));

endmodule

// File: rtl/rxaf_age.sv
module rxaf_age #(
  parameter int TICKS_PER_CHAR = 16,
  parameter int AGE_CHARS      = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run_ok,
  input  logic tick,
  input  logic clear_flag,
  output logic fire,
  output logic age_flag
);
  localparam int TW = $clog2(TICKS_PER_CHAR) + 1;
  localparam int CW = $clog2(AGE_CHARS) + 1;

  logic          armed;
  logic [TW-1:0] tick_cnt;
  logic [CW-1:0] char_cnt;
  logic          char_end;

  assign char_end = tick && (tick_cnt == TW'(TICKS_PER_CHAR - 1));
  assign fire = armed && run_ok && !restart && char_end &&
                (char_cnt == CW'(AGE_CHARS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      tick_cnt <= '0;
      char_cnt <= '0;
    end else if (restart) begin
      armed    <= 1'b1;
      tick_cnt <= '0;
      char_cnt <= '0;
    end else if (!run_ok) begin
      armed    <= 1'b0;
      tick_cnt <= '0;
      char_cnt <= '0;
    end else if (armed && tick) begin
      if (char_end) begin
        tick_cnt <= '0;
        if (char_cnt == CW'(AGE_CHARS - 1)) begin
          armed    <= 1'b0;
          char_cnt <= '0;
        end else begin
          char_cnt <= char_cnt + 1'b1;
        end
      end else begin
        tick_cnt <= tick_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             age_flag <= 1'b0;
    else if (clear_flag) age_flag <= 1'b0;
    else if (fire)       age_flag <= 1'b1;
  end

  assert_restart_blocks_age_R10: assert property (@(posedge clk) disable iff (rst)
    (restart && !age_flag) |=> !age_flag);

  assert_stopped_no_rise_R10: assert property (@(posedge clk) disable iff (rst)
    (!run_ok && !age_flag) |=> !age_flag);

  assert_clear_on_pop_R11: assert property (@(posedge clk) disable iff (rst)
    clear_flag |=> !age_flag);

endmodule

// File: rtl/uart_rx_age_fifo.sv
module uart_rx_age_fifo #(
  parameter int DEPTH          = 32,
  parameter int TRIG_W         = 6,
  parameter int TICKS_PER_CHAR = 16,
  parameter int AGE_CHARS      = 8,
  localparam int CNT_W         = $clog2(DEPTH + 1)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         rx_en_i,
  input  logic [TRIG_W-1:0]            trig_lvl_i,
  input  logic                         char_tick_i,
  input  logic                         push_i,
  input  logic [7:0]                   push_data_i,
  input  logic                         push_brk_i,
  input  logic                         push_frm_i,
  input  logic                         pop_i,
  output logic [12:0]                  pop_word_o,
  output logic                         rx_ready_o,
  output logic                         data_ready_o,
  output logic                         empty_o,
  output logic                         overrun_err_o,
  output logic                         break_det_o,
  output logic                         age_flag_o,
  output logic [CNT_W-1:0]             free_cnt_o
);
  import uart_rxaf_pkg::*;

  logic [CNT_W-1:0]  count_w;
  logic [CNT_W-1:0]  cnt_next_w;
  logic              full_w;
  logic              push_acc_w;
  logic              push_drop_w;
  logic              pop_valid_w;
  logic              last_slot_w;
  logic [WORD_W-1:0] wr_word_w;
  logic [WORD_W-1:0] rd_word_w;
  logic              age_fire_w;
  logic              age_run_w;

  assign full_w      = (count_w == CNT_W'(DEPTH));
  assign last_slot_w = (count_w == CNT_W'(DEPTH - 1));
  assign push_acc_w  = push_i && !full_w;
  assign push_drop_w = push_i && full_w;
  assign pop_valid_w = pop_i && (count_w != '0);
  assign cnt_next_w  = count_w + CNT_W'(push_acc_w) - CNT_W'(pop_valid_w);
  assign wr_word_w   = make_word(push_data_i, push_brk_i, push_frm_i, last_slot_w);
  assign age_run_w   = !empty_o && !rx_ready_o;

  rxaf_store #(.DEPTH(DEPTH), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (push_acc_w),
    .wr_word (wr_word_w),
    .rd_en   (pop_valid_w),
    .rd_word (rd_word_w),
    .count_o (count_w)
  );

  rxaf_status #(.CNT_W(CNT_W), .TRIG_W(TRIG_W)) u_status (
    .clk          (clk),
    .rst          (rst),
    .push_seen    (push_i),
    .push_dropped (push_drop_w),
    .brk_seen     (push_i && push_brk_i),
    .pop_valid    (pop_valid_w),
    .cnt_next     (cnt_next_w),
    .trig         (trig_lvl_i),
    .rx_ready     (rx_ready_o),
    .data_ready   (data_ready_o),
    .empty        (empty_o),
    .overrun_err  (overrun_err_o),
    .break_det    (break_det_o)
  );

  rxaf_age #(.TICKS_PER_CHAR(TICKS_PER_CHAR), .AGE_CHARS(AGE_CHARS)) u_age (
    .clk        (clk),
    .rst        (rst),
    .restart    (push_i || pop_valid_w),
    .run_ok     (age_run_w),
    .tick       (char_tick_i),
    .clear_flag (pop_valid_w),
    .fire       (age_fire_w),
    .age_flag   (age_flag_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pop_word_o <= '0;
    end else if (pop_i) begin
      pop_word_o <= pop_valid_w ? {1'b1, rd_word_w} : '0;
    end
  end

  assign free_cnt_o = rx_en_i ? (CNT_W'(DEPTH) - count_w) : '0;

  assert_empty_pop_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (pop_i && empty_o) |=> (pop_word_o == '0));

  assert_full_drop_R3: assert property (@(posedge clk) disable iff (rst)
    (push_i && (count_w == CNT_W'(DEPTH))) |=> overrun_err_o);

  assert_valid_pop_ready_bit_R2: assert property (@(posedge clk) disable iff (rst)
    (pop_i && data_ready_o) |=> pop_word_o[B_RDY]);

  assert_age_fire_waiting_R10: assert property (@(posedge clk) disable iff (rst)
    age_fire_w |=> (age_flag_o && $past(count_w) != '0));

endmodule

// File: tb/uart_rx_age_fifo_bench.sv
module uart_rx_age_fifo_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 32;
  localparam int TPC        = 16;
  localparam int AGEC       = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_en = 1'b1;
  logic [5:0]  trig = 6'd4;
  logic        tick = 1'b0;
  logic        push = 1'b0;
  logic [7:0]  pdata = 8'h00;
  logic        pbrk = 1'b0;
  logic        pfrm = 1'b0;
  logic        pop = 1'b0;
  logic [12:0] pop_word;
  logic        rx_ready, data_ready, empty, ovr_err, brk_det, age_flag;
  logic [5:0]  free_cnt;

  int n_checks = 0;
  int n_fail   = 0;
  bit reported = 0;

  int q[$];
  int m_word = 0;
  bit m_rdy = 0, m_empty = 1, m_ovr = 0, m_brk = 0, m_age = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_age_fifo #(.DEPTH(DEPTH), .TRIG_W(6), .TICKS_PER_CHAR(TPC), .AGE_CHARS(AGEC))
  u_uart_rx_age_fifo (
    .clk(clk), .rst(rst), .rx_en_i(rx_en), .trig_lvl_i(trig), .char_tick_i(tick),
    .push_i(push), .push_data_i(pdata), .push_brk_i(pbrk), .push_frm_i(pfrm),
    .pop_i(pop), .pop_word_o(pop_word), .rx_ready_o(rx_ready),
    .data_ready_o(data_ready), .empty_o(empty), .overrun_err_o(ovr_err),
    .break_det_o(brk_det), .age_flag_o(age_flag), .free_cnt_o(free_cnt)
  );

  function automatic int bench_word(int d, bit brk, bit frm, bit last);
    int w;
    w = brk ? 0 : (d & 'hFF);
    w = w | (brk ? 'h0B00 : 0);
    w = w | (frm ? 'h0A00 : 0);
    w = w | (last ? 'h0C00 : 0);
    return w;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic compare_all();
    check("R2 pop word", int'(pop_word), m_word);
    check("R5 rx_ready", int'(rx_ready), int'(m_rdy));
    check("R6 empty", int'(empty), int'(m_empty));
    check("R6 data_ready", int'(data_ready), int'(!m_empty));
    check("R3 overrun", int'(ovr_err), int'(m_ovr));
    check("R8 break", int'(brk_det), int'(m_brk));
    check("R11 age", int'(age_flag), int'(m_age));
    check("R12 free", int'(free_cnt), rx_en ? DEPTH - q.size() : 0);
  endtask

  // One clock: inputs already set after a falling edge.
  task automatic cyc(bit do_push, int d, bit brk, bit frm, bit do_pop);
    int pre;
    bit vpop;
    push = do_push; pdata = 8'(d); pbrk = brk; pfrm = frm; pop = do_pop;
    @(posedge clk);
    pre  = q.size();
    vpop = do_pop && pre > 0;
    if (do_pop) begin
      m_word = vpop ? ('h1000 | q[0]) : 0;
      if (vpop) begin
        void'(q.pop_front());
        m_age = 0;
      end
    end
    if (do_push) begin
      if (pre == DEPTH) m_ovr = 1;
      else q.push_back(bench_word(d, brk, frm, pre == DEPTH - 1));
      if (brk) m_brk = 1;
    end
    if (do_push || vpop) begin
      m_rdy   = (q.size() >= int'(trig));
      m_empty = (q.size() == 0);
    end
    @(negedge clk);
    compare_all();
    push = 0; pop = 0; pbrk = 0; pfrm = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 empty", int'(empty), 1);
    check("R1 data_ready", int'(data_ready), 0);
    check("R1 rx_ready", int'(rx_ready), 0);
    check("R1 flags", int'({ovr_err, brk_det, age_flag}), 0);
    check("R1 pop word", int'(pop_word), 0);

    // R5/R6 watermark at trig=4
    for (int i = 0; i < 3; i++) cyc(1, 'h41 + i, 0, 0, 0);
    check("R5 below level", int'(rx_ready), 0);
    cyc(1, 'h44, 0, 0, 0);
    check("R5 at level", int'(rx_ready), 1);
    cyc(0, 0, 0, 0, 1);
    check("R2 first word", int'(pop_word), 'h1041);
    check("R5 drop below", int'(rx_ready), 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1);
    check("R6 empty again", int'(empty), 1);
    // R7 empty pop
    cyc(0, 0, 0, 0, 1);
    check("R7 empty pop word", int'(pop_word), 0);
    check("R7 flags unchanged", int'({empty, rx_ready, data_ready}), 'b100);

    // R3/R4 fill and overflow
    for (int i = 0; i < DEPTH; i++) cyc(1, i + 'h10, 0, 0, 0);
    check("R12 full free", int'(free_cnt), 0);
    cyc(1, 'hEE, 0, 0, 0);
    check("R3 overrun set", int'(ovr_err), 1);
    for (int i = 0; i < DEPTH; i++) begin
      cyc(0, 0, 0, 0, 1);
      if (i == DEPTH - 1) check("R4 last slot tag", int'(pop_word), 'h1C00 | (i + 'h10));
    end
    check("R3 dropped char absent", int'(empty), 1);

    // R8 break, R9 framing
    cyc(1, 'h5A, 1, 0, 0);
    cyc(1, 'h66, 0, 1, 0);
    check("R8 break sticky", int'(brk_det), 1);
    cyc(0, 0, 0, 0, 1);
    check("R8 break word", int'(pop_word), 'h1B00);
    cyc(0, 0, 0, 0, 1);
    check("R9 framing word", int'(pop_word), 'h1A66);

    // R12 receiver disable
    cyc(1, 'h01, 0, 0, 0);
    rx_en = 0;
    #1 check("R12 disabled free", int'(free_cnt), 0);
    rx_en = 1;
    #1 check("R12 enabled free", int'(free_cnt), DEPTH - 1);
    cyc(0, 0, 0, 0, 1);

    // R10 ageing below level
    tick = 1;
    cyc(1, 'h77, 0, 0, 0);
    for (int i = 0; i < TPC * AGEC - 1; i++) cyc(0, 0, 0, 0, 0);
    check("R10 not yet aged", int'(age_flag), 0);
    m_age = 1;
    cyc(0, 0, 0, 0, 0);
    check("R10 aged", int'(age_flag), 1);
    cyc(0, 0, 0, 0, 1);
    check("R11 cleared by pop", int'(age_flag), 0);
    // R10 timer stopped while at level
    for (int i = 0; i < 4; i++) cyc(1, i, 0, 0, 0);
    for (int i = 0; i < 150; i++) cyc(0, 0, 0, 0, 0);
    check("R10 no ageing at level", int'(age_flag), 0);
    tick = 0;
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 1);

    // Random traffic with fixed seed
    void'($urandom(1234));
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 50) == 0) trig = 6'(1 + ($urandom % DEPTH));
      cyc(($urandom % 100) < 52, int'($urandom % 256),
          ($urandom % 40) == 0, ($urandom % 20) == 0, ($urandom % 100) < 45);
    end
    report();
  end

endmodule